// File: doc/BRIEF.md
# Toeplitz Five-Tuple Flow Hasher

This block turns a flow's five-tuple into a 32-bit Toeplitz hash and a flow-table index. The tuple consists of a 128-bit source address, a 128-bit destination address, a 16-bit source port, a 16-bit destination port and an 8-bit L4 protocol number. A 320-bit secret key is written one 32-bit word at a time through a simple write port. Before use, the key is conditioned by a fixed shift and a byte reversal.

A tuple enters through a valid/ready handshake. The engine consumes `LANES` input bytes per clock. It takes the bytes of the packed tuple from last to first and pairs them with key windows that advance from the start of the conditioned key. When the last step finishes, the raw hash and the truncated index appear together under `out_valid` and stay there until the consumer takes them. The engine snapshots the key and the table size when it accepts a tuple. Writes or table-size changes made during a hash therefore apply only from the next tuple.

Top module: `toeplitz_flow_hasher`

## Requirements
- R1: Key word address w (0 to 9) holds key bytes 4w..4w+3, with byte 4w in data bits 31:24. A write with an address of 10 or more changes nothing.
- R2: The key is conditioned before use. The 320-bit key, with byte 0 most significant, is shifted left by 5 with zero fill. Conditioned byte i is then byte 39−i of the shifted value.
- R3: The packed tuple has 40 bytes, T[0]..T[39]. T[0..15] hold the source address most significant byte first, and T[16..31] hold the destination address in the same order. T[32], T[33] hold the source port low byte then high byte. T[34], T[35] hold the destination port low byte then high byte. T[36] holds the protocol, and T[37..39] are zero.
- R4: Step i (0..39) uses input byte T[39−i] and the 40-bit window formed by conditioned key bytes i..i+4, where bytes past 39 read as zero. For each set bit at offset b (b=0 is the byte's MSB), window bits [39−b −: 32] are XORed into the hash, which starts at zero.
- R5: `out_index` = (`out_hash` >> 12) AND (`tbl_entries` − 1), with `tbl_entries` a power of two sampled when the tuple is accepted.
- R6: `in_ready` is high only when no hash is running and no result is held. A tuple is accepted on a clock edge with `in_valid` and `in_ready` high. `out_valid` rises exactly 40/`LANES` cycles after that edge.
- R7: While `out_valid` is high and `out_ready` is low, `out_hash` and `out_index` hold steady. The edge with both high clears `out_valid` and raises `in_ready`.
- R8: A key write during a running hash does not change that result. It does apply to the next tuple.
- R9: After reset, `out_valid` is low, `in_ready` is high and every key word is zero, so every tuple hashes to zero.
- R10: Changing `tbl_entries` while a hash runs does not change that result's index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| key_we | input | 1 | Key word write strobe |
| key_waddr | input | 4 | Key word address |
| key_wdata | input | 32 | Key word data |
| in_valid | input | 1 | Tuple offered |
| in_ready | output | 1 | Tuple can be accepted |
| src_addr | input | 128 | Source address |
| dst_addr | input | 128 | Destination address |
| src_port | input | 16 | Source port |
| dst_port | input | 16 | Destination port |
| l4_proto | input | 8 | L4 protocol number |
| tbl_entries | input | ENT_W (21) | Flow table entry count, power of two |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes the result |
| out_hash | output | 32 | Raw Toeplitz hash |
| out_index | output | 20 | Truncated table index |

## Verification
On every cycle, the checker enforces the handshake rules. It verifies that acceptance and a held result never overlap and that the result arrives at the fixed step latency. It also checks that a held result stays frozen and that the index equals the shifted hash masked by the table size captured at acceptance. The hash value itself is something only the bench scenarios can show: key conditioning, tuple byte order, the window stepping and zero fill at the key end. The same applies to ignoring out-of-range key writes and to isolating the running hash from key and table-size changes. The bench compares those results with an independent byte-level model and with hand-derived values.

// File: rtl/tfh_pkg.sv
package tfh_pkg;

    localparam int KEY_WORDS = 10;
    localparam int KEY_AW    = 4;
    localparam int KEY_BYTES = 40;
    localparam int KEY_BITS  = KEY_BYTES * 8;
    localparam int KEY_PAD   = KEY_BITS + 32;
    localparam int WIN_BITS  = 40;
    localparam int HASH_W    = 32;
    localparam int IDX_SHIFT = 12;
    localparam int IDX_W     = HASH_W - IDX_SHIFT;
    localparam int KEY_PRESHIFT = 5;

    typedef logic [KEY_BITS-1:0] vec320_t;

    typedef struct packed {
        logic [127:0] src;
        logic [127:0] dst;
        logic [15:0]  sport;
        logic [15:0]  dport;
        logic [7:0]   proto;
    } flow_tuple_t;

    typedef enum logic {
        ENG_IDLE = 1'b0,
        ENG_RUN  = 1'b1
    } eng_state_e;

    // Mirror byte order: byte k from the top becomes byte k from the bottom.
    function automatic vec320_t swap_bytes(input vec320_t v);
        vec320_t r;
        for (int k = 0; k < KEY_BYTES; k++) begin
            r[KEY_BITS-1-8*k -: 8] = v[8*k+7 -: 8];
        end
        return r;
    endfunction

    // Conditioned key: shift by the fixed amount, then mirror bytes.
    function automatic vec320_t condition_key(input vec320_t raw);
        return swap_bytes(raw << KEY_PRESHIFT);
    endfunction

    // Build the 40-byte packed tuple, then reverse it so that the byte
    // consumed first sits at the top of the vector.
    function automatic vec320_t serialize_tuple(input flow_tuple_t t);
        vec320_t fwd;
        fwd = {t.src, t.dst,
               t.sport[7:0], t.sport[15:8],
               t.dport[7:0], t.dport[15:8],
               t.proto, 24'h000000};
        return swap_bytes(fwd);
    endfunction

    // Contribution of one input byte against its 40-bit key window.
    function automatic logic [HASH_W-1:0] byte_term(input logic [WIN_BITS-1:0] win,
                                                    input logic [7:0] v);
        logic [HASH_W-1:0] acc;
        acc = '0;
        for (int b = 0; b < 8; b++) begin
            if (v[7-b]) acc = acc ^ win[WIN_BITS-1-b -: HASH_W];
        end
        return acc;
    endfunction

endpackage

// File: rtl/tfh_key_bank.sv
module tfh_key_bank
    import tfh_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [KEY_AW-1:0] waddr,
    input  logic [31:0]       wdata,
    output vec320_t           key_cond
);

    vec320_t raw_key;

    for (genvar w = 0; w < KEY_WORDS; w++) begin : g_word
        logic [31:0] word_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                word_q <= '0;
            end else if (we && (waddr == KEY_AW'(w))) begin
                word_q <= wdata;
            end
        end

        assign raw_key[KEY_BITS-1-32*w -: 32] = word_q;
    end

    assign key_cond = condition_key(raw_key);

endmodule

// File: rtl/tfh_engine.sv
module tfh_engine
    import tfh_pkg::*;
#(
    parameter int LANES = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  vec320_t           key_in,
    input  vec320_t           data_in,
    input  logic [IDX_W-1:0]  mask_in,
    output logic              busy,
    output logic              last_step,
    output logic [HASH_W-1:0] hash_nx,
    output logic [IDX_W-1:0]  mask_q
);

    // LANES must divide the 40 key bytes.
    localparam int STEPS = KEY_BYTES / LANES;
    localparam int CNT_W = $clog2(STEPS + 1);
    localparam int SHAMT = 8 * LANES;

    eng_state_e              state_q;
    logic [CNT_W-1:0]        cnt_q;
    logic [KEY_PAD-1:0]      key_sr;
    vec320_t                 dat_sr;
    logic [HASH_W-1:0]       acc_q;
    logic [LANES-1:0][HASH_W-1:0] lane_term;
    logic [HASH_W-1:0]       fold;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign lane_term[l] = byte_term(key_sr[KEY_PAD-1-8*l -: WIN_BITS],
                                        dat_sr[KEY_BITS-1-8*l -: 8]);
    end

    always_comb begin
        fold = acc_q;
        for (int l = 0; l < LANES; l++) begin
            fold = fold ^ lane_term[l];
        end
    end

    assign busy      = (state_q == ENG_RUN);
    assign last_step = busy && (cnt_q == CNT_W'(STEPS - 1));
    assign hash_nx   = fold;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ENG_IDLE;
            cnt_q   <= '0;
            key_sr  <= '0;
            dat_sr  <= '0;
            acc_q   <= '0;
            mask_q  <= '0;
        end else begin
            unique case (state_q)
                ENG_IDLE: begin
                    if (start) begin
                        key_sr  <= {key_in, 32'h0000_0000};
                        dat_sr  <= data_in;
                        acc_q   <= '0;
                        cnt_q   <= '0;
                        mask_q  <= mask_in;
                        state_q <= ENG_RUN;
                    end
                end
                ENG_RUN: begin
                    acc_q  <= fold;
                    key_sr <= key_sr << SHAMT;
                    dat_sr <= dat_sr << SHAMT;
                    cnt_q  <= cnt_q + CNT_W'(1);
                    if (last_step) state_q <= ENG_IDLE;
                end
                default: state_q <= ENG_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/tfh_result.sv
module tfh_result
    import tfh_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              capture,
    input  logic [HASH_W-1:0] hash_in,
    input  logic [IDX_W-1:0]  mask_in,
    input  logic              out_ready,
    output logic              out_valid,
    output logic [HASH_W-1:0] out_hash,
    output logic [IDX_W-1:0]  out_index
);

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_hash  <= '0;
            out_index <= '0;
        end else if (capture) begin
            out_valid <= 1'b1;
            out_hash  <= hash_in;
            out_index <= hash_in[HASH_W-1:IDX_SHIFT] & mask_in;
        end else if (out_valid && out_ready) begin
            out_valid <= 1'b0;
        end
    end

endmodule

// File: rtl/toeplitz_flow_hasher.sv
module toeplitz_flow_hasher
    import tfh_pkg::*;
#(
    parameter int LANES = 1,
    parameter int ENT_W = IDX_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              key_we,
    input  logic [KEY_AW-1:0] key_waddr,
    input  logic [31:0]       key_wdata,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [127:0]      src_addr,
    input  logic [127:0]      dst_addr,
    input  logic [15:0]       src_port,
    input  logic [15:0]       dst_port,
    input  logic [7:0]        l4_proto,
    input  logic [ENT_W-1:0]  tbl_entries,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [HASH_W-1:0] out_hash,
    output logic [IDX_W-1:0]  out_index
);

    vec320_t           key_cond;
    vec320_t           packed_tuple;
    flow_tuple_t       tup;
    logic [IDX_W-1:0]  mask_now;
    logic [IDX_W-1:0]  mask_run;
    logic              eng_busy;
    logic              eng_last;
    logic [HASH_W-1:0] eng_hash;
    logic              accept;

    assign tup = '{src: src_addr, dst: dst_addr, sport: src_port,
                   dport: dst_port, proto: l4_proto};
    assign packed_tuple = serialize_tuple(tup);
    assign mask_now     = IDX_W'(tbl_entries - ENT_W'(1));
    assign in_ready     = !eng_busy && !out_valid;
    assign accept       = in_valid && in_ready;

    tfh_key_bank u_keys (
        .clk      (clk),
        .rst      (rst),
        .we       (key_we),
        .waddr    (key_waddr),
        .wdata    (key_wdata),
        .key_cond (key_cond)
    );

    tfh_engine #(.LANES(LANES)) u_engine (
        .clk       (clk),
        .rst       (rst),
        .start     (accept),
        .key_in    (key_cond),
        .data_in   (packed_tuple),
        .mask_in   (mask_now),
        .busy      (eng_busy),
        .last_step (eng_last),
        .hash_nx   (eng_hash),
        .mask_q    (mask_run)
    );

    tfh_result u_result (
        .clk       (clk),
        .rst       (rst),
        .capture   (eng_last),
        .hash_in   (eng_hash),
        .mask_in   (mask_run),
        .out_ready (out_ready),
        .out_valid (out_valid),
        .out_hash  (out_hash),
        .out_index (out_index)
    );

endmodule

// File: rtl/tfh_checker.sv
module tfh_checker
    import tfh_pkg::*;
#(
    parameter int LANES = 1,
    parameter int ENT_W = IDX_W + 1
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic              in_ready,
    input logic [ENT_W-1:0]  tbl_entries,
    input logic              out_valid,
    input logic              out_ready,
    input logic [HASH_W-1:0] out_hash,
    input logic [IDX_W-1:0]  out_index
);

    localparam int STEPS = KEY_BYTES / LANES;
    localparam logic [7:0] SAT = 8'hFF;

    logic [7:0]       lat_cnt;
    logic [IDX_W-1:0] msk_seen;

    always_ff @(posedge clk) begin
        if (rst) begin
            lat_cnt  <= SAT;
            msk_seen <= '0;
        end else if (in_valid && in_ready) begin
            lat_cnt  <= 8'd0;
            msk_seen <= IDX_W'(tbl_entries - ENT_W'(1));
        end else if (!out_valid && lat_cnt != SAT) begin
            lat_cnt <= lat_cnt + 8'd1;
        end
    end

    // R6
    handshake_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(in_ready && out_valid));

    // R6
    latency_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(out_valid) |-> (lat_cnt == 8'(STEPS)));

    // R7
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_hash) && $stable(out_index)));

    // R7
    release_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready) |=> (!out_valid && in_ready));

    // R5
    index_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_index == (out_hash[HASH_W-1:IDX_SHIFT] & msk_seen)));

    // R9
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (!out_valid && in_ready));

endmodule

bind toeplitz_flow_hasher tfh_checker #(.LANES(LANES), .ENT_W(ENT_W)) u_tfh_chk (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .in_ready    (in_ready),
    .tbl_entries (tbl_entries),
    .out_valid   (out_valid),
    .out_ready   (out_ready),
    .out_hash    (out_hash),
    .out_index   (out_index)
);

// File: tb/test_toeplitz_flow_hasher.sv
module test_toeplitz_flow_hasher;

    localparam int LANES = 1;
    localparam int STEPS = 40 / LANES;
    localparam int ENT_W = 21;
    localparam int NV    = 6;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         key_we = 1'b0;
    logic [3:0]   key_waddr = '0;
    logic [31:0]  key_wdata = '0;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [127:0] src_addr = '0;
    logic [127:0] dst_addr = '0;
    logic [15:0]  src_port = '0;
    logic [15:0]  dst_port = '0;
    logic [7:0]   l4_proto = '0;
    logic [ENT_W-1:0] tbl_entries = 21'd16;
    logic         out_valid;
    logic         out_ready = 1'b0;
    logic [31:0]  out_hash;
    logic [19:0]  out_index;

    int checks = 0;
    int errors = 0;
    logic [31:0] kmodel [10];

    // {src, dst, sport, dport, proto, entries}
    localparam logic [316:0] VEC [NV] = '{
        {128'h20010db8_00000000_00000000_00000001, 128'h20010db8_00000000_00000000_000000fe,
         16'd49152, 16'd443, 8'd6, 21'd4096},
        {128'h0, 128'h0, 16'h1234, 16'h0, 8'd17, 21'd16},
        {128'h0, 128'h0, 16'h0, 16'hABCD, 8'd0, 21'd1048576},
        {128'hffffffff_ffffffff_ffffffff_ffffffff, 128'h0, 16'h0, 16'h0, 8'd0, 21'd256},
        {128'h0, 128'h0a000001_0a000002_c0a80101_c0a80102, 16'd80, 16'd8080, 8'd6, 21'd1},
        {128'hfe800000_00000000_02aa00ff_fe281c5a, 128'hff020000_00000000_00000000_00000001,
         16'd546, 16'd547, 8'd17, 21'd64}
    };

    toeplitz_flow_hasher #(.LANES(LANES)) i_toeplitz_flow_hasher (
        .clk(clk), .rst(rst), .key_we(key_we), .key_waddr(key_waddr), .key_wdata(key_wdata),
        .in_valid(in_valid), .in_ready(in_ready), .src_addr(src_addr), .dst_addr(dst_addr),
        .src_port(src_port), .dst_port(dst_port), .l4_proto(l4_proto), .tbl_entries(tbl_entries),
        .out_valid(out_valid), .out_ready(out_ready), .out_hash(out_hash), .out_index(out_index)
    );

    initial forever #5ns clk = ~clk;

    // Byte-level reference model built from R1..R4.
    function automatic logic [31:0] ref_hash(input logic [127:0] s, input logic [127:0] d,
                                             input logic [15:0] sp, input logic [15:0] dp,
                                             input logic [7:0] pr);
        logic [7:0] kb [41];
        logic [7:0] sb [40];
        logic [7:0] pb [44];
        logic [7:0] tb [40];
        logic [39:0] win;
        logic [31:0] h;
        for (int w = 0; w < 10; w++)
            for (int m = 0; m < 4; m++) kb[4*w+m] = kmodel[w][31-8*m -: 8];
        kb[40] = 8'h00;
        for (int k = 0; k < 40; k++) sb[k] = {kb[k][2:0], kb[k+1][7:3]};
        for (int i = 0; i < 44; i++) pb[i] = (i < 40) ? sb[39-i] : 8'h00;
        for (int m = 0; m < 16; m++) begin
            tb[m]    = s[127-8*m -: 8];
            tb[16+m] = d[127-8*m -: 8];
        end
        tb[32] = sp[7:0];  tb[33] = sp[15:8];
        tb[34] = dp[7:0];  tb[35] = dp[15:8];
        tb[36] = pr; tb[37] = 8'h00; tb[38] = 8'h00; tb[39] = 8'h00;
        h = 32'h0;
        for (int i = 0; i < 40; i++) begin
            win = {pb[i], pb[i+1], pb[i+2], pb[i+3], pb[i+4]};
            for (int b = 0; b < 8; b++)
                if (tb[39-i][7-b]) h = h ^ win[39-b -: 32];
        end
        return h;
    endfunction

    function automatic logic [19:0] ref_index(input logic [31:0] h, input logic [ENT_W-1:0] ent);
        logic [ENT_W-1:0] m;
        m = ent - 21'd1;
        return h[31:12] & m[19:0];
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic write_key(input logic [3:0] a, input logic [31:0] v);
        @(negedge clk);
        key_we = 1'b1; key_waddr = a; key_wdata = v;
        @(negedge clk);
        key_we = 1'b0;
        if (a < 4'd10) kmodel[a] = v;
    endtask

    task automatic start_tuple(input logic [127:0] s, input logic [127:0] d, input logic [15:0] sp,
                               input logic [15:0] dp, input logic [7:0] pr, input logic [ENT_W-1:0] ent);
        @(negedge clk);
        src_addr = s; dst_addr = d; src_port = sp; dst_port = dp; l4_proto = pr;
        tbl_entries = ent; in_valid = 1'b1;
        for (int n = 0; n < 1000 && !in_ready; n++) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic wait_result(output int lat);
        lat = 0;
        while (!out_valid && lat < 1000) begin
            @(negedge clk);
            lat++;
        end
    endtask

    task automatic release_result();
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
    endtask

    task automatic run_case(input string tag, input logic [127:0] s, input logic [127:0] d,
                            input logic [15:0] sp, input logic [15:0] dp, input logic [7:0] pr,
                            input logic [ENT_W-1:0] ent);
        logic [31:0] eh;
        int lat;
        eh = ref_hash(s, d, sp, dp, pr);
        start_tuple(s, d, sp, dp, pr, ent);
        wait_result(lat);
        chk({tag, " R6 latency"}, 32'(lat), 32'(STEPS));
        chk({tag, " R4 hash"}, out_hash, eh);
        chk({tag, " R5 index"}, 32'(out_index), 32'(ref_index(eh, ent)));
        release_result();
    endtask

    initial begin
        #2ms;
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        logic [31:0] eh;
        logic [31:0] hold_h;
        int lat;
        for (int w = 0; w < 10; w++) kmodel[w] = 32'h0;

        // R9: reset state
        repeat (3) @(negedge clk);
        chk("R9 out_valid in reset", 32'(out_valid), 32'd0);
        chk("R9 in_ready in reset", 32'(in_ready), 32'd1);
        rst = 1'b0;
        @(negedge clk);
        // R9: zero key after reset gives zero hash
        run_case("R9 zero key", VEC[0][316:189], VEC[0][188:61], 16'hFFFF, 16'hFFFF, 8'hFF, 21'd16);

        // R2 R4: hand values with an all-ones key
        for (int w = 0; w < 10; w++) write_key(4'(w), 32'hFFFF_FFFF);
        start_tuple(128'h0, 128'h0, 16'h0, 16'h0, 8'h80, 21'd16);
        wait_result(lat);
        chk("R2 proto MSB hash", out_hash, 32'hFFFF_FFFF);
        chk("R5 proto MSB index", 32'(out_index), 32'h0000_000F);
        release_result();
        start_tuple({1'b1, 127'h0}, 128'h0, 16'h0, 16'h0, 8'h00, 21'd1048576);
        wait_result(lat);
        chk("R4 key end zero fill hash", out_hash, 32'hFF00_0000);
        chk("R5 wide index", 32'(out_index), 32'h000F_F000);
        release_result();

        // Load a mixed key and walk the vector table (R1 R3 R4 R5 R6)
        for (int w = 0; w < 10; w++)
            write_key(4'(w), (32'h9E37_79B9 * 32'(w + 1)) ^ {8'(w * 29), 24'h5BD1E9});
        for (int v = 0; v < NV; v++)
            run_case($sformatf("R3 vec%0d", v), VEC[v][316:189], VEC[v][188:61],
                     VEC[v][60:45], VEC[v][44:29], VEC[v][28:21], VEC[v][20:0]);

        // R1: out-of-range key addresses are ignored
        write_key(4'd10, 32'hDEAD_BEEF);
        write_key(4'd15, 32'h1234_5678);
        run_case("R1 ignored addr", VEC[0][316:189], VEC[0][188:61],
                 VEC[0][60:45], VEC[0][44:29], VEC[0][28:21], VEC[0][20:0]);

        // R7: hold while not accepted, then release
        eh = ref_hash(VEC[5][316:189], VEC[5][188:61], VEC[5][60:45], VEC[5][44:29], VEC[5][28:21]);
        start_tuple(VEC[5][316:189], VEC[5][188:61], VEC[5][60:45], VEC[5][44:29], VEC[5][28:21], 21'd64);
        wait_result(lat);
        hold_h = out_hash;
        repeat (4) @(negedge clk);
        chk("R7 hash held", out_hash, hold_h);
        chk("R7 valid held", 32'(out_valid), 32'd1);
        chk("R7 ready low while held", 32'(in_ready), 32'd0);
        release_result();
        chk("R7 valid cleared", 32'(out_valid), 32'd0);
        chk("R7 ready back", 32'(in_ready), 32'd1);

        // R8 and R10: key write and table change during a hash
        eh = ref_hash(VEC[1][316:189], VEC[1][188:61], VEC[1][60:45], VEC[1][44:29], VEC[1][28:21]);
        start_tuple(VEC[1][316:189], VEC[1][188:61], VEC[1][60:45], VEC[1][44:29], VEC[1][28:21], 21'd4096);
        tbl_entries = 21'd2;
        write_key(4'd9, 32'h0F0F_A5A5);
        write_key(4'd0, 32'h8000_0001);
        wait_result(lat);
        chk("R8 running hash uses old key", out_hash, eh);
        chk("R10 index uses sampled size", 32'(out_index), 32'(ref_index(eh, 21'd4096)));
        release_result();
        run_case("R8 next tuple uses new key", VEC[1][316:189], VEC[1][188:61],
                 VEC[1][60:45], VEC[1][44:29], VEC[1][28:21], 21'd256);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule